// File: doc/BRIEF.md
# Bus Controller Command Decoder with Interrupt Status

This block sits between a host register port and the protocol sequencer of a parallel-bus storage controller. The host writes an 8-bit command byte. The decoder checks the opcode in bits 6..0 against the current link state reported by the sequencer. That state is one of three: free (not connected), connected as initiator, or connected as target. An accepted command produces a one-cycle start pulse on the line assigned to that command. The pulse comes with a DMA request flag taken from bit 7 of the byte. An opcode that is unknown, or that is not allowed in the current state, starts nothing and records an illegal-command interrupt.

Interrupt causes are gathered in an 8-bit status byte, and the interrupt request is high while any bit of that byte is set. Event pulses from the sequencer set their bits directly. The function-complete bit is set by a completion pulse only when an accepted command that is defined to interrupt is still waiting for completion. Commands defined as silent therefore never cause a function-complete interrupt. A host read returns the status byte and clears it, which drops the request.

Top module: `bpc_cmd_ctrl`

## Requirements
- R1: After reset, `start_o`, `start_dma_o`, `isr_o` and `irq_o` are all zero.
- R2: Opcodes 0x00, 0x01, 0x02 and 0x03 (no-op, flush, chip reset, bus reset) are accepted in every link state. They pulse `start_o` bits 0 to 3 respectively, one cycle after the write.
- R3: Opcodes 0x40 to 0x46 (select and reselect group) are accepted only when `link_state` is 2'b00 (free). Opcode 0x4n pulses `start_o` bit 4+n.
- R4: Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are accepted only when `link_state` is 2'b01 (initiator). They pulse `start_o` bits 11, 12, 13, 14, 15 and 16 respectively.
- R5: Opcode 0x27 (target disconnect) is accepted only when `link_state` is 2'b10 (target), and it pulses `start_o` bit 17. In state 2'b11, only the R2 opcodes are accepted.
- R6: A write whose opcode is unlisted, or is not allowed in the current state, gives no start pulse. It sets `isr_o` bit 6 (illegal command) in the cycle after the write.
- R7: `start_dma_o` pulses together with the start pulse of an accepted command whose byte has bit 7 set. It stays low for illegal writes.
- R8: `func_done` sets `isr_o` bit 3 only while an accepted, interrupting command is waiting; each such command is satisfied by one pulse. Opcodes 0x00 to 0x03, 0x44, 0x1A, 0x1B and 0x27 are silent and arm nothing.
- R9: `isr_o` bit 7 (bus reset) is set by an accepted 0x03 command or by `ev_pulse[5]`, but only when `rst_int_off` is low.
- R10: `ev_pulse` bits 4, 3, 2, 1 and 0 set `isr_o` bits 5 (disconnect), 4 (bus service), 2 (reselected), 1 (selected with attention) and 0 (selected) one cycle later.
- R11: While `isr_rd` is high, `isr_o` holds the value being read. On the next cycle the status byte holds only the causes raised in the read cycle, so a cause raised during a read is not lost.
- R12: `irq_o` is high exactly when `isr_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Host command-byte write strobe |
| cmd_byte | input | 8 | Command byte: bit 7 requests DMA, bits 6..0 are the opcode |
| link_state | input | 2 | 00 free, 01 initiator, 10 target, 11 none |
| rst_int_off | input | 1 | Suppresses bus-reset interrupt reporting |
| func_done | input | 1 | Completion pulse from the sequencer |
| ev_pulse | input | 6 | Event pulses: 5 bus reset, 4 disconnect, 3 service, 2 reselected, 1 selected with attention, 0 selected |
| isr_rd | input | 1 | Host read of the status byte (clear on read) |
| start_o | output | 18 | One-hot start pulses, one per command |
| start_dma_o | output | 1 | DMA request for the started command |
| isr_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default package constants: 18 command lines, an 8-bit status byte and 6 event inputs. That build brings within reach every one of the 256 command-byte values in each of the 4 link states, with and without the DMA bit and with reset reporting both on and off. Random completion pulses, events and reads are mixed in among the writes. This covers stray completions with nothing armed, reads that coincide with new causes, and completions that coincide with a new interrupting command.

// File: rtl/bpc_cmd_pkg.sv
package bpc_cmd_pkg;
    localparam int OP_W     = 8;
    localparam int NUM_CMD  = 18;
    localparam int IDX_W    = $clog2(NUM_CMD);
    localparam int ISR_W    = 8;
    localparam int EV_W     = 6;
    localparam int LINK_W   = 2;

    localparam int IDX_BUSRST = 3;

    localparam int B_RST   = 7;
    localparam int B_ILL   = 6;
    localparam int B_DISC  = 5;
    localparam int B_SVC   = 4;
    localparam int B_FC    = 3;
    localparam int B_RESEL = 2;
    localparam int B_SATN  = 1;
    localparam int B_SEL   = 0;

    typedef enum logic [LINK_W-1:0] {
        LS_FREE = 2'd0,
        LS_INIT = 2'd1,
        LS_TGT  = 2'd2,
        LS_NONE = 2'd3
    } link_e;

    typedef struct packed {
        logic             legal;
        logic             arms;
        logic [IDX_W-1:0] idx;
    } dec_t;
endpackage

// File: rtl/bpc_cmd_decode.sv
module bpc_cmd_decode
    import bpc_cmd_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [LINK_W-1:0] link_i,
    output dec_t              dec_o
);
    logic [OP_W-2:0] code;
    assign code = op_i[OP_W-2:0];

    always_comb begin
        dec_o = '0;
        case (code)
            7'h00, 7'h01, 7'h02, 7'h03: begin
                dec_o.legal = 1'b1;
                dec_o.idx   = IDX_W'(code[1:0]);
                dec_o.arms  = 1'b0;
            end
            7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46: begin
                dec_o.legal = (link_i == LS_FREE);
                dec_o.idx   = IDX_W'(4) + IDX_W'(code[2:0]);
                dec_o.arms  = (code[2:0] != 3'd4);
            end
            7'h10, 7'h11, 7'h12: begin
                dec_o.legal = (link_i == LS_INIT);
                dec_o.idx   = IDX_W'(11) + IDX_W'(code[1:0]);
                dec_o.arms  = 1'b1;
            end
            7'h18: begin
                dec_o.legal = (link_i == LS_INIT);
                dec_o.idx   = IDX_W'(14);
                dec_o.arms  = 1'b1;
            end
            7'h1A, 7'h1B: begin
                dec_o.legal = (link_i == LS_INIT);
                dec_o.idx   = IDX_W'(15) + IDX_W'(code[0]);
                dec_o.arms  = 1'b0;
            end
            7'h27: begin
                dec_o.legal = (link_i == LS_TGT);
                dec_o.idx   = IDX_W'(17);
                dec_o.arms  = 1'b0;
            end
            default: dec_o = '0;
        endcase
    end
endmodule

// File: rtl/bpc_isr_bank.sv
module bpc_isr_bank
    import bpc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] set_i,
    input  logic             clr_i,
    output logic [ISR_W-1:0] isr_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [ISR_W-1:0] isr;
        logic             irq;
    } bank_t;

    bank_t b_d, b_q;
    logic [ISR_W-1:0] nxt;

    for (genvar g = 0; g < ISR_W; g++) begin : g_bit
        assign nxt[g] = (b_q.isr[g] & ~clr_i) | set_i[g];
    end

    always_comb begin
        b_d.isr = nxt;
        b_d.irq = |nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign isr_o = b_q.isr;
    assign irq_o = b_q.irq;

    // R11
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (isr_o == '0));

    // R12
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(clr_i));

    // R12
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (isr_o != '0));
endmodule

// File: rtl/bpc_cmd_ctrl.sv
module bpc_cmd_ctrl
    import bpc_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [OP_W-1:0]    cmd_byte,
    input  logic [LINK_W-1:0]  link_state,
    input  logic               rst_int_off,
    input  logic               func_done,
    input  logic [EV_W-1:0]    ev_pulse,
    input  logic               isr_rd,
    output logic [NUM_CMD-1:0] start_o,
    output logic               start_dma_o,
    output logic [ISR_W-1:0]   isr_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_CMD-1:0] start;
        logic               dma;
        logic               arm;
    } ctl_t;

    ctl_t s_d, s_q;
    dec_t dec;
    logic accept;
    logic [ISR_W-1:0] set_v;

    bpc_cmd_decode i_dec (
        .op_i   (cmd_byte),
        .link_i (link_state),
        .dec_o  (dec)
    );

    always_comb begin
        accept = cmd_wr & dec.legal;
        set_v  = '0;
        set_v[B_RST]   = ev_pulse[5] & ~rst_int_off;
        set_v[B_DISC]  = ev_pulse[4];
        set_v[B_SVC]   = ev_pulse[3];
        set_v[B_RESEL] = ev_pulse[2];
        set_v[B_SATN]  = ev_pulse[1];
        set_v[B_SEL]   = ev_pulse[0];
        if (cmd_wr && !dec.legal)
            set_v[B_ILL] = 1'b1;
        if (accept && dec.idx == IDX_W'(IDX_BUSRST) && !rst_int_off)
            set_v[B_RST] = 1'b1;
        if (func_done && s_q.arm)
            set_v[B_FC] = 1'b1;

        s_d.arm   = (s_q.arm & ~func_done) | (accept & dec.arms);
        s_d.start = accept ? (NUM_CMD'(1) << dec.idx) : '0;
        s_d.dma   = accept & cmd_byte[OP_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bpc_isr_bank i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (isr_rd),
        .isr_o (isr_o),
        .irq_o (irq_o)
    );

    assign start_o     = s_q.start;
    assign start_dma_o = s_q.dma;

    // R2 R3 R4 R5
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o));

    // R6
    illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !dec.legal) |=> (start_o == '0 && isr_o[B_ILL]));

    // R7
    dma_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_dma_o |-> $onehot(start_o));

    // R8
    fc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_o[B_FC]) |-> $past(func_done));

    // R9
    rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_o[B_RST]) |-> !$past(rst_int_off));
endmodule

// File: tb/test_bpc_cmd_ctrl.sv
module test_bpc_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [1:0]  link_state = '0;
    logic        rst_int_off = 1'b0;
    logic        func_done = 1'b0;
    logic [5:0]  ev_pulse = '0;
    logic        isr_rd = 1'b0;
    logic [17:0] start_o;
    logic        start_dma_o;
    logic [7:0]  isr_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    logic [7:0]  m_isr = '0;
    bit          m_arm = 0;
    logic [17:0] m_start = '0;
    bit          m_dma = 0;
    int unsigned lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    bpc_cmd_ctrl i_bpc_cmd_ctrl (
        .clk, .rst_n, .cmd_wr, .cmd_byte, .link_state, .rst_int_off,
        .func_done, .ev_pulse, .isr_rd, .start_o, .start_dma_o, .isr_o, .irq_o
    );

    function automatic int unsigned nxt_rand(int unsigned v);
        return v * 32'd1664525 + 32'd1013904223;
    endfunction

    // independent command table
    function automatic void ref_dec(input logic [7:0] op, input logic [1:0] st,
                                    output bit ok, output int pos, output bit intr);
        int c;
        c = int'(op & 8'h7f);
        ok = 0; pos = 0; intr = 0;
        if (c <= 3) begin
            ok = 1; pos = c; intr = 0;
        end else if (c >= 'h40 && c <= 'h46) begin
            ok = (st == 2'b00); pos = c - 'h40 + 4; intr = (c != 'h44);
        end else if (c >= 'h10 && c <= 'h12) begin
            ok = (st == 2'b01); pos = c - 'h10 + 11; intr = 1;
        end else if (c == 'h18) begin
            ok = (st == 2'b01); pos = 14; intr = 1;
        end else if (c == 'h1A || c == 'h1B) begin
            ok = (st == 2'b01); pos = c - 'h1A + 15; intr = 0;
        end else if (c == 'h27) begin
            ok = (st == 2'b10); pos = 17; intr = 0;
        end
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2/R3/R4/R5/R6 start_o", 32'(start_o), 32'(m_start));
        chk("R7 start_dma_o", 32'(start_dma_o), 32'(m_dma));
        chk("R6/R8/R9/R10/R11 isr_o", 32'(isr_o), 32'(m_isr));
        chk("R12 irq_o", 32'(irq_o), 32'(m_isr != 0));
    endtask

    // reference update at the clock edge, from the applied inputs only
    always @(posedge clk) begin
        if (rst_n) begin
            bit ok, intr;
            int pos;
            logic [7:0] s;
            ref_dec(cmd_byte, link_state, ok, pos, intr);
            s = 8'h00;
            if (ev_pulse[5] && !rst_int_off) s[7] = 1;
            s[5] = ev_pulse[4]; s[4] = ev_pulse[3];
            s[2] = ev_pulse[2]; s[1] = ev_pulse[1]; s[0] = ev_pulse[0];
            if (cmd_wr && !ok) s[6] = 1;
            if (cmd_wr && ok && pos == 3 && !rst_int_off) s[7] = 1;
            if (func_done && m_arm) s[3] = 1;
            m_isr   = (isr_rd ? 8'h00 : m_isr) | s;
            m_arm   = (m_arm && !func_done) || (cmd_wr && ok && intr);
            m_start = (cmd_wr && ok) ? (18'd1 << pos) : 18'd0;
            m_dma   = cmd_wr && ok && cmd_byte[7];
        end
    end

    // called at a falling edge: drive, pass one edge, compare at next falling edge
    task automatic cyc(input bit wr, input logic [7:0] op, input logic [1:0] st,
                       input bit cfg, input bit dn, input logic [5:0] ev, input bit rd);
        cmd_wr = wr; cmd_byte = op; link_state = st; rst_int_off = cfg;
        func_done = dn; ev_pulse = ev; isr_rd = rd;
        if (rd) chk("R11 read value", 32'(isr_o), 32'(m_isr));
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 0; func_done = 0; ev_pulse = '0; isr_rd = 0;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 start_o", 32'(start_o), 0);
        chk("R1 start_dma_o", 32'(start_dma_o), 0);
        chk("R1 isr_o", 32'(isr_o), 0);
        chk("R1 irq_o", 32'(irq_o), 0);
        rst_n = 1;
        @(negedge clk);
        compare_all();

        // R8: stray completion with nothing armed
        cyc(0, 8'h00, 2'b00, 0, 1, 6'h00, 0);
        // R9: bus reset command reported, then masked
        cyc(1, 8'h03, 2'b01, 0, 0, 6'h00, 0);
        cyc(0, 8'h00, 2'b01, 0, 0, 6'h00, 1);
        cyc(1, 8'h83, 2'b01, 1, 0, 6'h20, 0);
        // R3 R8: select with attention, complete later; R7 dma
        cyc(1, 8'hC2, 2'b00, 0, 0, 6'h00, 0);
        cyc(0, 8'h00, 2'b00, 0, 1, 6'h00, 0);
        cyc(0, 8'h00, 2'b00, 0, 1, 6'h00, 1);
        // R8: silent enable-reselect then completion
        cyc(1, 8'h44, 2'b00, 0, 0, 6'h00, 0);
        cyc(0, 8'h00, 2'b00, 0, 1, 6'h00, 0);
        // R4 R5 R6: wrong-state attempts
        cyc(1, 8'h10, 2'b00, 0, 0, 6'h00, 0);
        cyc(1, 8'h27, 2'b01, 0, 0, 6'h00, 1);
        cyc(1, 8'h27, 2'b10, 0, 0, 6'h00, 0);
        // R10: every event bit; R11: read coincident with a new cause
        cyc(0, 8'h00, 2'b00, 0, 0, 6'h1F, 0);
        cyc(0, 8'h00, 2'b00, 0, 0, 6'h01, 1);
        cyc(0, 8'h00, 2'b00, 0, 0, 6'h00, 1);

        // sweep: all bytes in all states, with random traffic around them
        for (int st = 0; st < 4; st++) begin
            for (int b = 0; b < 256; b++) begin
                bit cfg, dn, rd;
                logic [5:0] ev;
                lfsr = nxt_rand(lfsr);
                cfg = lfsr[20];
                dn  = lfsr[21] & lfsr[22];
                rd  = lfsr[23] & lfsr[24];
                ev  = (lfsr[27:25] == 3'd0) ? lfsr[13:8] : 6'h00;
                cyc(1, 8'(b), 2'(st), cfg, dn, ev, rd);
                lfsr = nxt_rand(lfsr);
                cyc(0, 8'h00, 2'(st), cfg, lfsr[18], 6'h00, lfsr[19]);
            end
        end
        cyc(0, 8'h00, 2'b00, 0, 0, 6'h00, 1);
        chk("R11 cleared after final read", 32'(isr_o), 0);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule